// File: doc/BRIEF.md
# QRS Energy Envelope Pipeline

This block turns a stream of signed single-lead ECG samples into an unsigned energy envelope. In that envelope each QRS complex shows up as a broad, tall hump. Every accepted sample goes through four stages in a fixed order. The first is a band-pass built from two shift-only recursive sections. The second is a five-point slope estimator. The third squares the slope. The fourth is a moving-window averager whose window length follows the sample rate chosen at build time.

One instance serves one lead. Samples arrive with a valid strobe and may come with gaps. Each stage advances only when its own valid is high, so a gap in the input moves through the pipeline as a gap in the output and does not disturb any result. The output is the feature signal that a later beat detector compares against its thresholds. The block itself makes no beat decision.

Top module: `qrs_energy_pipe`

## Requirements
- R1: The output for each accepted sample equals band-pass, then slope, then square, then window average, applied in that order to the sample history since reset.
- R2: The low-pass section updates as lp = lp + ((x - lp) >>> 2), with arithmetic (floor) shifts and a state of 0 after reset.
- R3: The high-pass section keeps a baseline b that updates as b = b + ((lp - b) >>> 5). Its result is lp minus the baseline held before the update, saturated to the signed 16-bit range [-32768, 32767].
- R4: The slope stage outputs (2*y[n] + y[n-1] - y[n-3] - 2*y[n-4]) >>> 3, where y is the band-pass result and its history is 0 after reset.
- R5: The squarer outputs the slope times itself as an unsigned 32-bit value, saturated at 2^32-1. It is never negative and never above 24576^2.
- R6: The integrator sums the last N squared values. For the first N samples after reset, the value leaving the window counts as 0.
- R7: The output energy is the window sum shifted right by log2(N), so it never exceeds the largest possible squared value.
- R8: The parameter RATE_HZ selects N: 32 for rates below 1000 Hz and 128 for 1000 Hz and above.
- R9: out_valid repeats in_valid exactly 5 clock cycles later, with no bubbles added. in_sample is ignored while in_valid is low, and out_energy holds its value while out_valid is low.
- R10: A synchronous active-high reset clears every stage and the window. During and right after reset, out_valid and out_energy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: in_sample holds a new sample |
| in_sample | input | 16 | Signed ECG sample |
| out_valid | output | 1 | Strobe: out_energy holds a new result |
| out_energy | output | 32 | Unsigned window-averaged energy |

## Verification
Wrong recursive state in the low-pass or baseline section shows up as a wrong energy value about 4 cycles after the next accepted sample. Because those sections feed back on themselves, the error then persists. A stale slope history or a wrong squarer value corrupts up to five consecutive outputs and then leaves the window sum offset for the next N samples. A wrong ring pointer or fill flag appears only once the window wraps, that is N samples after reset. For that reason the stimulus runs long enough to wrap the 128-entry window several times, and it also includes gaps in the valid strobe.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  localparam int LP_SHIFT   = 2;
  localparam int HP_SHIFT   = 5;
  localparam int SLOPE_SH   = 3;
  localparam int PIPE_DEPTH = 5;

  function automatic int win_log2(input int rate_hz);
    if (rate_hz >= 1000) return 7;
    return 5;
  endfunction
endpackage

// File: rtl/qrs_bandpass.sv
module qrs_bandpass #(
  parameter int DATA_W = 16,
  parameter int LP_SH  = qrs_pkg::LP_SHIFT,
  parameter int HP_SH  = qrs_pkg::HP_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_v,
  input  logic signed [DATA_W-1:0] in_x,
  output logic                     out_v,
  output logic signed [DATA_W-1:0] out_y
);
  localparam int AW = DATA_W + 2;
  localparam logic signed [AW-1:0] POS_LIM = {3'b000, {(DATA_W-1){1'b1}}};
  localparam logic signed [AW-1:0] NEG_LIM = {3'b111, {(DATA_W-1){1'b0}}};

  logic signed [AW-1:0] lp_q, base_q, x_ext, lp_next, hp_raw, base_next;
  logic signed [DATA_W-1:0] y_next;
  logic lp_v_q;

  always_comb begin
    x_ext     = {{2{in_x[DATA_W-1]}}, in_x};
    lp_next   = lp_q + ((x_ext - lp_q) >>> LP_SH);
    hp_raw    = lp_q - base_q;
    base_next = base_q + (hp_raw >>> HP_SH);
    if (hp_raw > POS_LIM)      y_next = POS_LIM[DATA_W-1:0];
    else if (hp_raw < NEG_LIM) y_next = NEG_LIM[DATA_W-1:0];
    else                       y_next = hp_raw[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q   <= '0;
      base_q <= '0;
      lp_v_q <= 1'b0;
      out_v  <= 1'b0;
      out_y  <= '0;
    end else begin
      lp_v_q <= in_v;
      out_v  <= lp_v_q;
      if (in_v) lp_q <= lp_next;
      if (lp_v_q) begin
        base_q <= base_next;
        out_y  <= y_next;
      end
    end
  end
endmodule

// File: rtl/qrs_slope.sv
module qrs_slope #(
  parameter int DATA_W = 16,
  parameter int SH     = qrs_pkg::SLOPE_SH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_v,
  input  logic signed [DATA_W-1:0] in_y,
  output logic                     out_v,
  output logic signed [DATA_W-1:0] out_d
);
  localparam int TAPS = 4;
  localparam int SW   = DATA_W + 3;

  logic signed [DATA_W-1:0] hist_q [TAPS];
  logic signed [SW-1:0] acc, scaled;

  always_comb begin
    acc = (SW'(in_y) <<< 1) + SW'(hist_q[0]) - SW'(hist_q[2]) - (SW'(hist_q[3]) <<< 1);
    scaled = acc >>> SH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) hist_q[k] <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        hist_q[0] <= in_y;
        for (int k = 1; k < TAPS; k++) hist_q[k] <= hist_q[k-1];
        out_d <= scaled[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/qrs_square.sv
module qrs_square #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_v,
  input  logic signed [IN_W-1:0] in_d,
  output logic                   out_v,
  output logic [OUT_W-1:0]       out_sq
);
  localparam int PW = 2 * IN_W;

  logic signed [PW-1:0] prod;
  logic [OUT_W-1:0] sq_next;

  assign prod = in_d * in_d;

  generate
    if (PW > OUT_W) begin : g_sat
      always_comb begin
        if ($unsigned(prod) > PW'({OUT_W{1'b1}})) sq_next = {OUT_W{1'b1}};
        else                                      sq_next = prod[OUT_W-1:0];
      end
    end else begin : g_fit
      always_comb sq_next = OUT_W'($unsigned(prod));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v  <= 1'b0;
      out_sq <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) out_sq <= sq_next;
    end
  end
endmodule

// File: rtl/qrs_window_avg.sv
module qrs_window_avg #(
  parameter int IN_W  = 32,
  parameter int LOG2N = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic [IN_W-1:0] in_e,
  output logic            out_v,
  output logic [IN_W-1:0] out_avg
);
  localparam int N  = 1 << LOG2N;
  localparam int SW = IN_W + LOG2N;

  logic [IN_W-1:0]  ring_mem [N];
  logic [IN_W-1:0]  leave_q, leave_eff;
  logic [LOG2N-1:0] wr_ptr, rd_addr;
  logic             full_q;
  logic [SW-1:0]    sum_q, sum_next;

  // Read one slot ahead when writing, so leave_q always holds the slot wr_ptr points at.
  assign rd_addr = in_v ? wr_ptr + LOG2N'(1) : wr_ptr;

  always_ff @(posedge clk) begin
    if (in_v) ring_mem[wr_ptr] <= in_e;
    leave_q <= ring_mem[rd_addr];
  end

  always_comb begin
    leave_eff = full_q ? leave_q : '0;
    sum_next  = sum_q + SW'(in_e) - SW'(leave_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      full_q  <= 1'b0;
      sum_q   <= '0;
      out_v   <= 1'b0;
      out_avg <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        wr_ptr  <= wr_ptr + LOG2N'(1);
        if (wr_ptr == LOG2N'(N - 1)) full_q <= 1'b1;
        sum_q   <= sum_next;
        out_avg <= sum_next[SW-1:LOG2N];
      end
    end
  end
endmodule

// File: rtl/qrs_energy_pipe.sv
module qrs_energy_pipe #(
  parameter int DATA_W  = 16,
  parameter int OUT_W   = 32,
  parameter int RATE_HZ = 250
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_energy
);
  localparam int WIN_LOG2 = qrs_pkg::win_log2(RATE_HZ);

  logic                     bp_v, sl_v, sq_v;
  logic signed [DATA_W-1:0] bp_y, sl_d;
  logic [OUT_W-1:0]         sq_d;

  qrs_bandpass #(.DATA_W(DATA_W)) u_bp (
    .clk(clk), .rst(rst), .in_v(in_valid), .in_x(in_sample),
    .out_v(bp_v), .out_y(bp_y)
  );

  qrs_slope #(.DATA_W(DATA_W)) u_sl (
    .clk(clk), .rst(rst), .in_v(bp_v), .in_y(bp_y),
    .out_v(sl_v), .out_d(sl_d)
  );

  qrs_square #(.IN_W(DATA_W), .OUT_W(OUT_W)) u_sq (
    .clk(clk), .rst(rst), .in_v(sl_v), .in_d(sl_d),
    .out_v(sq_v), .out_sq(sq_d)
  );

  qrs_window_avg #(.IN_W(OUT_W), .LOG2N(WIN_LOG2)) u_win (
    .clk(clk), .rst(rst), .in_v(sq_v), .in_e(sq_d),
    .out_v(out_valid), .out_avg(out_energy)
  );
endmodule

// File: rtl/qrs_energy_chk.sv
module qrs_energy_chk #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_energy,
  input logic             sq_valid,
  input logic [OUT_W-1:0] sq_data
);
  localparam int DEPTH = qrs_pkg::PIPE_DEPTH;
  localparam longint CEIL_L = 64'd9 << (2 * DATA_W - 6);
  localparam logic [OUT_W-1:0] SQ_CEIL = CEIL_L[OUT_W-1:0];

  logic [DEPTH-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[DEPTH-2:0], in_valid};
  end

  // R9
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[DEPTH-1]);

  // R9
  energy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_energy));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_energy == '0));

  // R5
  square_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> sq_data <= SQ_CEIL);

  // R7
  energy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_energy <= SQ_CEIL);
endmodule

bind qrs_energy_pipe qrs_energy_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_energy(out_energy), .sq_valid(sq_v), .sq_data(sq_d)
);

// File: tb/qrs_energy_pipe_test.sv
module qrs_energy_pipe_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic [1:0]  ov;
  logic [31:0] oe [2];

  int checks = 0;
  int fails  = 0;
  string tag = "R10 reset";
  logic [15:0] lfsr = 16'hACE1;

  bit     vq [$];
  int     lp_m [2];
  int     bs_m [2];
  int     bh   [2][4];
  longint sumv [2];
  longint ring [2][$];
  longint expq [2][$];

  always #10 clk = ~clk;

  qrs_energy_pipe #(.RATE_HZ(250)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov[0]), .out_energy(oe[0])
  );

  qrs_energy_pipe #(.RATE_HZ(1000)) uut_hi (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov[1]), .out_energy(oe[1])
  );

  function automatic int win_log(input int k);
    return (k == 0) ? 5 : 7;  // R8: 250 Hz -> 32, 1000 Hz -> 128
  endfunction

  task automatic fail(input string what, input longint act, input longint exp);
    fails++;
    $display("FAIL %s: actual %0d expected %0d", what, act, exp);
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      lp_m[k] = 0; bs_m[k] = 0; sumv[k] = 0;
      for (int j = 0; j < 4; j++) bh[k][j] = 0;
      ring[k].delete();
      expq[k].delete();
    end
    vq.delete();
    for (int j = 0; j < 5; j++) vq.push_back(1'b0);
  endtask

  task automatic model_step(input int x);
    for (int k = 0; k < 2; k++) begin
      int d, y, slope;
      longint sq, old;
      lp_m[k] = lp_m[k] + ((x - lp_m[k]) >>> 2);          // R2
      d = lp_m[k] - bs_m[k];                               // R3
      bs_m[k] = bs_m[k] + (d >>> 5);
      y = (d > 32767) ? 32767 : ((d < -32768) ? -32768 : d);
      slope = (2*y + bh[k][0] - bh[k][2] - 2*bh[k][3]) >>> 3;  // R4
      bh[k][3] = bh[k][2]; bh[k][2] = bh[k][1]; bh[k][1] = bh[k][0]; bh[k][0] = y;
      sq = longint'(slope) * longint'(slope);              // R5
      if (sq > 64'hFFFF_FFFF) sq = 64'hFFFF_FFFF;
      ring[k].push_back(sq);                               // R6
      old = 0;
      if (ring[k].size() > (1 << win_log(k))) old = ring[k].pop_front();
      sumv[k] = sumv[k] + sq - old;
      expq[k].push_back(sumv[k] >>> win_log(k));           // R7
    end
  endtask

  task automatic compare();
    bit ev;
    ev = vq.pop_front();
    for (int k = 0; k < 2; k++) begin
      longint e;
      e = 0;
      if (ev) e = expq[k].pop_front();
      checks++;
      if (ov[k] !== ev)
        fail($sformatf("R9 valid latency (win %0d)", 1 << win_log(k)), longint'(ov[k]), longint'(ev));
      else if (ev && ($isunknown(oe[k]) || longint'(oe[k]) != e))
        fail($sformatf("%s (win %0d)", tag, 1 << win_log(k)), longint'(oe[k]), e);
    end
  endtask

  task automatic cycle(input bit v, input int x);
    @(negedge clk);
    compare();
    in_valid  = v;
    in_sample = 16'(x);
    if (v) model_step(x);
    vq.push_back(v);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (ov[k] !== 1'b0 || oe[k] !== 32'd0)
        fail("R10 reset state", longint'(oe[k]) + longint'(ov[k]), 0);
    end
    rst = 1'b0;
    model_reset();
  endtask

  function automatic int noise();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fail("R9 watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(3);

    tag = "R1 R2 R3 step response";
    for (int i = 0; i < 200; i++) cycle(1'b1, 10000);
    for (int i = 0; i < 60; i++) cycle(1'b1, -7000);

    tag = "R4 impulse";
    for (int i = 0; i < 40; i++) cycle(1'b1, 0);
    cycle(1'b1, 20000);
    for (int i = 0; i < 60; i++) cycle(1'b1, 0);

    tag = "R3 R5 full-scale square wave saturation";
    for (int i = 0; i < 300; i++) cycle(1'b1, ((i / 4) % 2 == 0) ? 32767 : -32768);

    tag = "R9 gaps with ignored data";
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = (i % 3 != 2) && (i % 17 != 5);
      cycle(v, v ? (noise() >>> 2) : noise());
    end

    tag = "R6 R7 R8 long run wrapping both windows";
    for (int i = 0; i < 1500; i++)
      cycle(1'b1, (((i % 200) < 6) ? 12000 : 0) + (noise() >>> 6));

    do_reset(2);
    tag = "R10 R1 restart after reset";
    for (int i = 0; i < 200; i++) cycle(1'b1, (i % 50 < 4) ? -15000 : (noise() >>> 5));
    for (int i = 0; i < 8; i++) cycle(1'b0, noise());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule